// File: doc/BRIEF.md
# Multi-Type Reset Controller

This block sequences resets for a processor system. It tells three reset kinds apart: power-on, cold and software. Each kind drives its own set of reset outputs, one per logic domain. A request is taken only while the system bus is quiet, which means both the bus-grant and the response-valid inputs are low. The hard kinds (power-on and cold) reset every domain. While reset is held, they also read a configuration word one bit per clock from a serial input and keep it for the core. A software reset clears only the external-interface domain. The core domain, which covers the internal and cache clocks, the caches and the coprocessor and FPU register files, keeps running, and the configuration word is not touched.

After power-up the controller holds every domain in reset until a hard reset has completed. Once the requests are gone, and for hard kinds once the full word has been captured, each domain output is released through its own two-stage synchronizing chain.

Top module: `multi_reset_ctrl`

## Requirements
- R1: After the asynchronous power-up reset, both domain resets are low, `cfg_valid` is low and `rst_kind` reads 0. A software request is ignored in this state until a hard reset has completed.
- R2: A request is accepted only when `bus_grant` and `resp_valid` are both low at the clock edge. A request seen while either is high changes neither the outputs nor `rst_kind`.
- R3: On an accepted hard request `rst_kind` becomes 0 (power-on) if `pwr_on_det` is 1, and 1 (cold) if it is 0. On an accepted software request it becomes 2. It updates at the accepting edge.
- R4: When hard and software requests are accepted in the same cycle, or a hard request arrives during a software reset, a hard reset is performed.
- R5: A hard reset drives `rst_core_n` and `rst_ext_n` low from the first edge after the accepting edge.
- R6: A software reset drives only `rst_ext_n` low. `rst_core_n` stays high, and `cfg_word` and `cfg_valid` keep their values.
- R7: On a hard reset, `cfg_word` bit i equals `mode_din` sampled at edge i+1 after the accepting edge, for i = 0 to CFG_W-1 (LSB first).
- R8: `mode_clk` toggles on each capture edge, starting high after the first. It is low whenever no capture is running.
- R9: `cfg_valid` clears at a hard reset's accepting edge, rises at the edge of the last captured bit, and holds through software resets.
- R10: A reset ends at the first edge where both requests are low and, for hard kinds, capture is done. That is edge max(CFG_W+1, H) after acceptance for a hard reset, or edge H for a software reset, where H is the first edge at which the request is seen low. The affected domain outputs rise SYNC_STAGES edges after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous power-up reset, active low |
| hard_req | input | 1 | Hard reset request, active high |
| soft_req | input | 1 | Software reset request, active high |
| pwr_on_det | input | 1 | 1 marks the first reset after power-up |
| bus_grant | input | 1 | Bus grant; blocks acceptance when high |
| resp_valid | input | 1 | Response valid; blocks acceptance when high |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Pacing toggle during capture |
| cfg_word | output | CFG_W | Captured configuration word |
| cfg_valid | output | 1 | Configuration word complete |
| rst_kind | output | 2 | Kind of last accepted reset (0 power-on, 1 cold, 2 software) |
| rst_core_n | output | 1 | Core domain reset, active low |
| rst_ext_n | output | 1 | External-interface domain reset, active low |

## Verification
The bench builds the block with its defaults: CFG_W = 64 and SYNC_STAGES = 2. The full-width word lets every bit position of the serial capture be checked against random data, and it lets request hold times be shorter than, equal to and longer than the capture window. That covers both ways a hard reset can end. With two synchronizer stages the release edge is exact and the cycle before it is also checked, so an off-by-one in the release timing is caught.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef enum logic [1:0] {
    KIND_POR  = 2'd0,
    KIND_COLD = 2'd1,
    KIND_SOFT = 2'd2
  } rst_kind_e;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_IDLE = 2'd1,
    ST_HARD = 2'd2,
    ST_SOFT = 2'd3
  } seq_state_e;

  localparam int DOM_CORE = 0;
  localparam int DOM_EXT  = 1;
  localparam int NUM_DOM  = 2;

  // Domains each reset kind pulls low.
  function automatic logic [NUM_DOM-1:0] kind_dom_mask(rst_kind_e k);
    logic [NUM_DOM-1:0] m;
    m = '1;
    if (k == KIND_SOFT) begin
      m = '0;
      m[DOM_EXT] = 1'b1;
    end
    return m;
  endfunction

  function automatic rst_kind_e hard_kind(logic por);
    return por ? KIND_POR : KIND_COLD;
  endfunction

endpackage

// File: rtl/rstc_seq.sv
module rstc_seq
  import rstc_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic               hard_req,
  input  logic               soft_req,
  input  logic               pwr_on_det,
  input  logic               bus_grant,
  input  logic               resp_valid,
  input  logic               cap_done,
  output seq_state_e         state_o,
  output rst_kind_e          kind_o,
  output logic               cap_start,
  output logic [NUM_DOM-1:0] dom_req
);

  seq_state_e state, state_nxt;
  rst_kind_e  kind, kind_nxt;
  logic       bus_quiet, hard_acc, soft_acc, reqs_gone;

  assign bus_quiet = !bus_grant && !resp_valid;
  assign hard_acc  = hard_req && bus_quiet;
  assign soft_acc  = soft_req && bus_quiet;
  assign reqs_gone = !hard_req && !soft_req;

  always_comb begin
    state_nxt = state;
    kind_nxt  = kind;
    cap_start = 1'b0;
    case (state)
      ST_HOLD, ST_IDLE, ST_SOFT: begin
        if (hard_acc) begin
          state_nxt = ST_HARD;
          kind_nxt  = hard_kind(pwr_on_det);
          cap_start = 1'b1;
        end else if (state == ST_IDLE && soft_acc) begin
          state_nxt = ST_SOFT;
          kind_nxt  = KIND_SOFT;
        end else if (state == ST_SOFT && reqs_gone) begin
          state_nxt = ST_IDLE;
        end
      end
      ST_HARD: if (cap_done && reqs_gone) state_nxt = ST_IDLE;
      default: state_nxt = ST_HOLD;
    endcase
  end

  always_comb begin
    case (state)
      ST_HOLD: dom_req = '1;
      ST_IDLE: dom_req = '0;
      default: dom_req = kind_dom_mask(kind);
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= ST_HOLD;
      kind  <= KIND_POR;
    end else begin
      state <= state_nxt;
      kind  <= kind_nxt;
    end
  end

  assign state_o = state;
  assign kind_o  = kind;

endmodule

// File: rtl/rstc_cfg_capture.sv
module rstc_cfg_capture #(
  parameter int CFG_W = 64
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             start,
  input  logic             mode_din,
  output logic             mode_clk,
  output logic [CFG_W-1:0] cfg_word,
  output logic             cfg_valid,
  output logic             busy,
  output logic             done
);

  localparam int CW = $clog2(CFG_W + 1);

  logic [CW-1:0]    cnt;
  logic [CFG_W-1:0] sh;
  logic             last;

  // Newest bit enters at the top; after CFG_W shifts the first bit sits at bit 0.
  function automatic logic [CFG_W-1:0] shift_in(logic [CFG_W-1:0] cur, logic b);
    return {b, cur[CFG_W-1:1]};
  endfunction

  assign busy = (cnt != CW'(CFG_W));
  assign done = !busy;
  assign last = (cnt == CW'(CFG_W - 1));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt       <= CW'(CFG_W);
      sh        <= '0;
      cfg_valid <= 1'b0;
      mode_clk  <= 1'b0;
    end else if (start) begin
      cnt       <= '0;
      cfg_valid <= 1'b0;
      mode_clk  <= 1'b0;
    end else if (busy) begin
      sh       <= shift_in(sh, mode_din);
      cnt      <= cnt + CW'(1);
      mode_clk <= last ? 1'b0 : ~mode_clk;
      if (last) cfg_valid <= 1'b1;
    end
  end

  assign cfg_word = sh;

endmodule

// File: rtl/rstc_rel_sync.sv
module rstc_rel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold,
  output logic rst_n
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   chain <= '0;
    else if (hold) chain <= '0;
    else           chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain[STAGES-1];

endmodule

// File: rtl/multi_reset_ctrl.sv
module multi_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int CFG_W       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             hard_req,
  input  logic             soft_req,
  input  logic             pwr_on_det,
  input  logic             bus_grant,
  input  logic             resp_valid,
  input  logic             mode_din,
  output logic             mode_clk,
  output logic [CFG_W-1:0] cfg_word,
  output logic             cfg_valid,
  output logic [1:0]       rst_kind,
  output logic             rst_core_n,
  output logic             rst_ext_n
);

  seq_state_e         seq_state;
  rst_kind_e          seq_kind;
  logic               cap_start, cap_busy, cap_done;
  logic [NUM_DOM-1:0] dom_req, dom_rst_n;

  rstc_seq u_seq (
    .clk        (clk),
    .arst_n     (arst_n),
    .hard_req   (hard_req),
    .soft_req   (soft_req),
    .pwr_on_det (pwr_on_det),
    .bus_grant  (bus_grant),
    .resp_valid (resp_valid),
    .cap_done   (cap_done),
    .state_o    (seq_state),
    .kind_o     (seq_kind),
    .cap_start  (cap_start),
    .dom_req    (dom_req)
  );

  rstc_cfg_capture #(.CFG_W(CFG_W)) u_cap (
    .clk       (clk),
    .arst_n    (arst_n),
    .start     (cap_start),
    .mode_din  (mode_din),
    .mode_clk  (mode_clk),
    .cfg_word  (cfg_word),
    .cfg_valid (cfg_valid),
    .busy      (cap_busy),
    .done      (cap_done)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    rstc_rel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .hold   (dom_req[d]),
      .rst_n  (dom_rst_n[d])
    );
  end

  assign rst_kind   = seq_kind;
  assign rst_core_n = dom_rst_n[DOM_CORE];
  assign rst_ext_n  = dom_rst_n[DOM_EXT];

endmodule

// File: rtl/multi_reset_ctrl_chk.sv
module multi_reset_ctrl_chk
  import rstc_pkg::*;
#(
  parameter int CFG_W = 64
) (
  input logic             clk,
  input logic             arst_n,
  input logic             hard_req,
  input logic             bus_grant,
  input logic             resp_valid,
  input seq_state_e       state,
  input logic             cap_start,
  input logic             mode_clk,
  input logic [CFG_W-1:0] cfg_word,
  input logic             cfg_valid,
  input logic             rst_core_n
);

  // R1
  hold_keeps_core_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_HOLD) |-> !rst_core_n);

  // R2
  quiet_bus_gate_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ((bus_grant || resp_valid) && state == ST_IDLE) |=> (state == ST_IDLE));

  // R4
  hard_wins_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state != ST_HARD && hard_req && !bus_grant && !resp_valid) |=> (state == ST_HARD));

  // R5
  core_low_in_hard_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_HARD) |=> !rst_core_n);

  // R6
  soft_spares_core_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_SOFT && rst_core_n) |=> rst_core_n);

  // R8
  mode_clk_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
    mode_clk |=> !mode_clk);

  // R8
  mode_clk_capture_only_chk: assert property (@(posedge clk) disable iff (!arst_n)
    mode_clk |-> !cfg_valid);

  // R9
  valid_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    cap_start |=> !cfg_valid);

  // R9
  word_stable_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (cfg_valid && !cap_start) |=> $stable(cfg_word));

  // R10
  release_after_capture_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_core_n) |-> cfg_valid);

endmodule

bind multi_reset_ctrl multi_reset_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .hard_req   (hard_req),
  .bus_grant  (bus_grant),
  .resp_valid (resp_valid),
  .state      (seq_state),
  .cap_start  (cap_start),
  .mode_clk   (mode_clk),
  .cfg_word   (cfg_word),
  .cfg_valid  (cfg_valid),
  .rst_core_n (rst_core_n)
);

// File: tb/multi_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module multi_reset_ctrl_tb_top;

  localparam int CFG_W = 64;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic hard_req = 1'b0, soft_req = 1'b0, pwr_on_det = 1'b0;
  logic bus_grant = 1'b0, resp_valid = 1'b0, mode_din = 1'b0;
  logic             mode_clk, cfg_valid, rst_core_n, rst_ext_n;
  logic [CFG_W-1:0] cfg_word;
  logic [1:0]       rst_kind;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [CFG_W-1:0] cur_cfg = '0;

  always #10 clk = ~clk;

  multi_reset_ctrl #(.CFG_W(CFG_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .arst_n(arst_n), .hard_req(hard_req), .soft_req(soft_req),
    .pwr_on_det(pwr_on_det), .bus_grant(bus_grant), .resp_valid(resp_valid),
    .mode_din(mode_din), .mode_clk(mode_clk), .cfg_word(cfg_word),
    .cfg_valid(cfg_valid), .rst_kind(rst_kind), .rst_core_n(rst_core_n),
    .rst_ext_n(rst_ext_n)
  );

  function automatic logic [1:0] exp_kind(bit hard, bit por);
    if (!hard) return 2'd2;
    return por ? 2'd0 : 2'd1;
  endfunction

  function automatic int hard_leave(int h);
    return (h > CFG_W + 1) ? h : CFG_W + 1;
  endfunction

  task automatic check(string req, bit ok, logic [CFG_W-1:0] act, logic [CFG_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_hard(bit por, logic [CFG_W-1:0] data, int h, bit with_soft);
    int leave;
    int highs;
    leave = hard_leave(h);
    highs = 0;
    hard_req = 1'b1; soft_req = with_soft; pwr_on_det = por;
    bus_grant = 1'b0; resp_valid = 1'b0; mode_din = 1'b0;
    @(negedge clk);
    check("R3 kind", rst_kind == exp_kind(1, por), rst_kind, exp_kind(1, por));
    if (with_soft) check("R4 hard wins", rst_kind != 2'd2, rst_kind, exp_kind(1, por));
    for (int k = 1; k <= leave + SYNC; k++) begin
      hard_req = (k < h); soft_req = 1'b0;
      mode_din = (k <= CFG_W) ? data[k-1] : 1'($urandom);
      bus_grant = 1'($urandom); resp_valid = 1'($urandom);
      @(negedge clk);
      if (k <= CFG_W && mode_clk) highs++;
      if (k == 1) begin
        check("R5 core low", rst_core_n == 1'b0, rst_core_n, 0);
        check("R5 ext low", rst_ext_n == 1'b0, rst_ext_n, 0);
        check("R9 valid clear", cfg_valid == 1'b0, cfg_valid, 0);
      end
      if (k == CFG_W) begin
        check("R7 word", cfg_word == data, cfg_word, data);
        check("R9 valid set", cfg_valid == 1'b1, cfg_valid, 1);
        check("R8 toggles", highs == CFG_W / 2, highs, CFG_W / 2);
      end
      if (k == leave + SYNC - 1) check("R10 not yet", rst_core_n == 1'b0, rst_core_n, 0);
      if (k == leave + SYNC) begin
        check("R10 core rise", rst_core_n == 1'b1, rst_core_n, 1);
        check("R10 ext rise", rst_ext_n == 1'b1, rst_ext_n, 1);
        check("R8 idle low", mode_clk == 1'b0, mode_clk, 0);
      end
    end
    bus_grant = 1'b0; resp_valid = 1'b0;
    cur_cfg = data;
  endtask

  task automatic do_soft(int h);
    soft_req = 1'b1; hard_req = 1'b0; bus_grant = 1'b0; resp_valid = 1'b0;
    @(negedge clk);
    check("R3 soft kind", rst_kind == 2'd2, rst_kind, 2);
    for (int k = 1; k <= h + SYNC; k++) begin
      soft_req = (k < h);
      bus_grant = 1'($urandom); resp_valid = 1'($urandom);
      mode_din = 1'($urandom);
      @(negedge clk);
      check("R6 core kept", rst_core_n == 1'b1, rst_core_n, 1);
      check("R6 word kept", cfg_word == cur_cfg && cfg_valid, cfg_word, cur_cfg);
      check("R8 no toggle", mode_clk == 1'b0, mode_clk, 0);
      if (k == 1) check("R6 ext low", rst_ext_n == 1'b0, rst_ext_n, 0);
      if (k == h + SYNC - 1) check("R10 soft not yet", rst_ext_n == 1'b0, rst_ext_n, 0);
      if (k == h + SYNC) check("R10 soft rise", rst_ext_n == 1'b1, rst_ext_n, 1);
    end
    bus_grant = 1'b0; resp_valid = 1'b0;
  endtask

  task automatic gate_test();
    logic [1:0] k0;
    k0 = rst_kind;
    for (int i = 0; i < 16; i++) begin
      hard_req = 1'($urandom); soft_req = ~hard_req;
      bus_grant = (i < 8); resp_valid = (i >= 8) | 1'($urandom);
      @(negedge clk);
      check("R2 gated", rst_core_n && rst_ext_n && rst_kind == k0, rst_kind, k0);
    end
    hard_req = 1'b0; soft_req = 1'b0; bus_grant = 1'b0; resp_valid = 1'b0;
    @(negedge clk);
    check("R2 idle after", rst_core_n && rst_ext_n, rst_core_n, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    // R1: power-up hold, software request ignored
    for (int i = 0; i < 6; i++) begin
      soft_req = 1'b1;
      @(negedge clk);
      check("R1 hold", !rst_core_n && !rst_ext_n && !cfg_valid && rst_kind == 2'd0,
            {rst_core_n, rst_ext_n, cfg_valid, rst_kind}, 0);
    end
    soft_req = 1'b0;
    do_hard(1'b1, {$urandom, $urandom}, 1, 1'b0);
    gate_test();
    do_soft(5);
    do_soft(1);
    // R4: hard request upgrades an ongoing software reset
    soft_req = 1'b1;
    repeat (3) @(negedge clk);
    do_hard(1'b0, {$urandom, $urandom}, 2, 1'b1);
    // R4: both requests in the same cycle
    do_hard(1'b1, {$urandom, $urandom}, 3, 1'b1);
    // R10 boundaries of the hold time
    do_hard(1'b0, {CFG_W{1'b1}}, CFG_W + 1, 1'b0);
    do_hard(1'b0, {CFG_W/2{2'b01}}, CFG_W + 2, 1'b0);
    do_hard(1'b1, {$urandom, $urandom}, 100, 1'b0);
    for (int it = 0; it < 30; it++) begin
      if ($urandom_range(0, 1) == 0) do_soft(int'($urandom_range(1, 20)));
      else do_hard(1'($urandom), {$urandom, $urandom},
                   int'($urandom_range(1, CFG_W + 40)), 1'($urandom));
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule